// File: doc/BRIEF.md
# Machine and Supervisor Control Register File with Write Legalization

This block holds the privileged control and status registers of a 32-bit hart and applies a write-any-read-legal rule to every software write. Each register keeps only the bits it implements, fixes up reserved encodings, and presents derived fields on read. The supervisor status, interrupt-pending and interrupt-enable registers are filtered windows onto the machine copies, not separate storage.

An access is one cycle: the core presents an address with a write strobe or a read strobe. Read data and the illegal flag are combinational from the current state. A write lands at the next clock edge. The block also produces a one-cycle strobe that tells the address-translation logic to discard cached translations. It raises this strobe after writes that can change how addresses are translated. A 64-bit retired-instruction counter is included, which a retire pulse advances.

Top module: `csr_warl_file`

## Requirements
- R1: The interrupt-delegation register (0x303) keeps only bits 1, 5, 9 and 12 (mask 0x1222). The machine interrupt-enable register (0x304) keeps only bits 1, 3, 5, 7, 9 and 12 (mask 0x12AA).
- R2: The exception-delegation register (0x302) keeps only cause bits 0, 3, 8, 12, 13 and 15 (mask 0xB109).
- R3: The previous-privilege field of machine status (0x300, bits 12:11) is legalized on write. Without user mode it becomes 3. The value 2, and any value without supervisor mode, becomes 0.
- R4: Status bit 31 reads as 1 exactly when bits 14:13 or bits 16:15 are 11. Bits 16:15 are writable only when HAS_EXT is set. Bit 8 is writable only with supervisor mode. Bits 1, 3, 5, 7, 13-14 and 17-22 are writable.
- R5: Writes to mepc (0x341), sepc (0x141) and dpc (0x7B1) clear bit 0. Writes to stvec (0x105) clear bits 1:0. Writes to mtvec (0x305) clear bit 1.
- R6: In misa (0x301), only bits 0, 2, 3, 5 and 12 are writable, and only where MISA_RST has them set. A written value with bit 5 clear also clears bit 3. A write with bit 2 clear is dropped entirely while pc_odd_half_i is 1.
- R7: A write to supervisor pending (0x144) can change only mip bit 1, and only when that bit is delegated. A write to supervisor enable (0x104) changes only delegated bits of mie. Reads of both return the machine copy ANDed with the delegation register. A machine pending write (0x344) changes only bits 1 and 5.
- R8: Supervisor status (0x100) reads machine status masked to bits 1, 5, 8, 13-16, 18 and 19, plus bit 31. Writes through it change only those bits.
- R9: tlb_flush_o is 1 in the cycle after a satp (0x180) write. It is also 1 after a status write that changes bits 12:11, 17, 18 or 19. It is 0 after any other access.
- R10: A write to the low half (0xB02) or high half (0xB82) of the retire counter replaces that half. The stored 64-bit value is then reduced by one and increased by retire_i of the same cycle. Otherwise, retire_i adds one.
- R11: An access to an unimplemented address raises csr_illegal_o and returns 0. The read-only identity registers (0xF11-0xF13) read 0, and 0xF14 reads HART_ID. A write to any address with bits 11:10 equal to 11 is illegal and changes nothing.
- R12: After reset every register reads 0, except misa, which reads MISA_RST.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_addr_i | input | 12 | Register address |
| csr_wdata_i | input | 32 | Write data |
| csr_we_i | input | 1 | Write strobe |
| csr_re_i | input | 1 | Read strobe |
| pc_odd_half_i | input | 1 | Bit 1 of the current program counter |
| retire_i | input | 1 | One instruction retired this cycle |
| csr_rdata_o | output | 32 | Read data, 0 when illegal |
| csr_illegal_o | output | 1 | Access to an unimplemented or read-only address |
| tlb_flush_o | output | 1 | Translation flush strobe, one cycle |

## Verification
Read data and the illegal flag are combinational, so they are checked in the same cycle as the access. A write is due at the edge that ends its cycle, so every value read back is compared one cycle or more after that write. The flush strobe is registered and is sampled exactly in the cycle after the write that causes it. The counter is read back one cycle after a write or a retire pulse. The driver queues each expected item in the cycle it drives the stimulus. The monitor pops and compares at the falling edge of that same cycle, so a result can be checked only in the cycle it is due.

// File: rtl/csr_pkg.sv
package csr_pkg;
  localparam int XLEN = 32;
  typedef logic [XLEN-1:0] word_t;

  localparam logic [11:0] A_SSTATUS  = 12'h100;
  localparam logic [11:0] A_SIE      = 12'h104;
  localparam logic [11:0] A_STVEC    = 12'h105;
  localparam logic [11:0] A_SSCRATCH = 12'h140;
  localparam logic [11:0] A_SEPC     = 12'h141;
  localparam logic [11:0] A_SCAUSE   = 12'h142;
  localparam logic [11:0] A_STVAL    = 12'h143;
  localparam logic [11:0] A_SIP      = 12'h144;
  localparam logic [11:0] A_SATP     = 12'h180;
  localparam logic [11:0] A_MSTATUS  = 12'h300;
  localparam logic [11:0] A_MISA     = 12'h301;
  localparam logic [11:0] A_MEDELEG  = 12'h302;
  localparam logic [11:0] A_MIDELEG  = 12'h303;
  localparam logic [11:0] A_MIE      = 12'h304;
  localparam logic [11:0] A_MTVEC    = 12'h305;
  localparam logic [11:0] A_MSCRATCH = 12'h340;
  localparam logic [11:0] A_MEPC     = 12'h341;
  localparam logic [11:0] A_MCAUSE   = 12'h342;
  localparam logic [11:0] A_MTVAL    = 12'h343;
  localparam logic [11:0] A_MIP      = 12'h344;
  localparam logic [11:0] A_DPC      = 12'h7b1;
  localparam logic [11:0] A_RET_LO   = 12'hb02;
  localparam logic [11:0] A_RET_HI   = 12'hb82;
  localparam logic [11:0] A_ID_VEND  = 12'hf11;
  localparam logic [11:0] A_ID_ARCH  = 12'hf12;
  localparam logic [11:0] A_ID_IMPL  = 12'hf13;
  localparam logic [11:0] A_ID_HART  = 12'hf14;

  // status field positions
  localparam int ST_SIE = 1, ST_MIE = 3, ST_SPIE = 5, ST_MPIE = 7, ST_SPP = 8;
  localparam int ST_MPP = 11, ST_FS = 13, ST_XS = 15;
  localparam int ST_MPRV = 17, ST_SUM = 18, ST_MXR = 19, ST_TVM = 20, ST_TW = 21, ST_TSR = 22;
  localparam int ST_SD = XLEN - 1;

  // interrupt lines
  localparam int IRQ_SSI = 1, IRQ_MSI = 3, IRQ_STI = 5, IRQ_MTI = 7;
  localparam int IRQ_SEI = 9, IRQ_COP = 12;

  // exception causes open to delegation
  localparam int EXC_IFETCH_ALIGN = 0, EXC_BRK = 3, EXC_UCALL = 8;
  localparam int EXC_IPF = 12, EXC_LPF = 13, EXC_SPF = 15;

  // misa letters
  localparam int ISA_A = 0, ISA_C = 2, ISA_D = 3, ISA_F = 5, ISA_M = 12, ISA_S = 18, ISA_U = 20;

  function automatic word_t bit_w(input int pos);
    return word_t'(1) << pos;
  endfunction

  localparam word_t IRQ_DELEG_MASK = bit_w(IRQ_SSI) | bit_w(IRQ_STI) | bit_w(IRQ_SEI) | bit_w(IRQ_COP);
  localparam word_t IRQ_ALL_MASK   = IRQ_DELEG_MASK | bit_w(IRQ_MSI) | bit_w(IRQ_MTI);
  localparam word_t EXC_DELEG_MASK = bit_w(EXC_IFETCH_ALIGN) | bit_w(EXC_BRK) | bit_w(EXC_UCALL)
                                   | bit_w(EXC_IPF) | bit_w(EXC_LPF) | bit_w(EXC_SPF);
  localparam word_t ISA_RW_MASK    = bit_w(ISA_A) | bit_w(ISA_C) | bit_w(ISA_D) | bit_w(ISA_F) | bit_w(ISA_M);

  typedef enum logic [1:0] {PRV_U = 2'd0, PRV_S = 2'd1, PRV_H = 2'd2, PRV_M = 2'd3} prv_e;

  function automatic logic [1:0] legal_prv(input logic [1:0] req, input bit has_u, input bit has_s);
    if (!has_u) return PRV_M;
    if (req == PRV_H || !has_s) return PRV_U;
    return req;
  endfunction

  // plain data registers: address and the bits they keep
  localparam int NPLAIN = 12;
  function automatic logic [11:0] plain_addr(input int i);
    case (i)
      0: return A_MSCRATCH;
      1: return A_MCAUSE;
      2: return A_MTVAL;
      3: return A_SSCRATCH;
      4: return A_SCAUSE;
      5: return A_STVAL;
      6: return A_SATP;
      7: return A_MEPC;
      8: return A_SEPC;
      9: return A_DPC;
      10: return A_MTVEC;
      default: return A_STVEC;
    endcase
  endfunction

  function automatic word_t plain_keep(input int i);
    case (i)
      7, 8, 9: return ~word_t'(1);
      10: return ~word_t'(2);
      11: return ~word_t'(3);
      default: return '1;
    endcase
  endfunction
endpackage

// File: rtl/csr_status.sv
module csr_status
  import csr_pkg::*;
#(
  parameter bit HAS_U   = 1'b1,
  parameter bit HAS_S   = 1'b1,
  parameter bit HAS_EXT = 1'b0
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  mwr_i,
  input  logic  swr_i,
  input  word_t wdata_i,
  output word_t mstatus_o,
  output word_t sstatus_o,
  output logic  flush_req_o
);
  localparam word_t FS_M = word_t'(3) << ST_FS;
  localparam word_t XS_M = word_t'(3) << ST_XS;
  localparam word_t MPP_M = word_t'(3) << ST_MPP;
  localparam word_t BASE_M = bit_w(ST_SIE) | bit_w(ST_SPIE) | bit_w(ST_MIE) | bit_w(ST_MPIE)
                           | FS_M | bit_w(ST_MPRV) | bit_w(ST_SUM) | bit_w(ST_MXR)
                           | bit_w(ST_TW) | bit_w(ST_TVM) | bit_w(ST_TSR);
  localparam word_t WR_M = BASE_M | (HAS_S ? bit_w(ST_SPP) : '0) | (HAS_EXT ? XS_M : '0);
  localparam word_t S_VIEW = bit_w(ST_SIE) | bit_w(ST_SPIE) | bit_w(ST_SPP) | FS_M | XS_M
                           | bit_w(ST_SUM) | bit_w(ST_MXR);
  localparam word_t FLUSH_M = MPP_M | bit_w(ST_MPRV) | bit_w(ST_SUM) | bit_w(ST_MXR);
  localparam word_t RST_V = word_t'(legal_prv(PRV_U, HAS_U, HAS_S)) << ST_MPP;

  word_t st_q, src, nxt;
  logic  dirty;

  always_comb begin
    src = swr_i ? ((st_q & ~S_VIEW) | (wdata_i & S_VIEW)) : wdata_i;
    nxt = (st_q & ~WR_M) | (src & WR_M);
    nxt[ST_MPP +: 2] = legal_prv(src[ST_MPP +: 2], HAS_U, HAS_S);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= RST_V;
    else if (mwr_i || swr_i) st_q <= nxt;
  end

  assign flush_req_o = (mwr_i || swr_i) && (((nxt ^ st_q) & FLUSH_M) != '0);
  assign dirty       = (&st_q[ST_FS +: 2]) || (&st_q[ST_XS +: 2]);
  assign mstatus_o   = st_q | (word_t'(dirty) << ST_SD);
  assign sstatus_o   = mstatus_o & (S_VIEW | bit_w(ST_SD));

  a_r3_mpp_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q[ST_MPP +: 2] != PRV_H);
  a_r4_xs_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    HAS_EXT || st_q[ST_XS +: 2] == 2'b00);
  a_r8_sview_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swr_i && !mwr_i) |=> ((st_q & ~S_VIEW) == $past(st_q & ~S_VIEW)));
endmodule

// File: rtl/csr_irq.sv
module csr_irq
  import csr_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  mip_wr_i,
  input  logic  sip_wr_i,
  input  logic  mie_wr_i,
  input  logic  sie_wr_i,
  input  logic  ideleg_wr_i,
  input  logic  edeleg_wr_i,
  input  word_t wdata_i,
  output word_t mip_o,
  output word_t mie_o,
  output word_t ideleg_o,
  output word_t edeleg_o,
  output word_t sip_o,
  output word_t sie_o
);
  localparam word_t PEND_M = bit_w(IRQ_SSI) | bit_w(IRQ_STI);

  word_t mip_q, mie_q, ideleg_q, edeleg_q;
  word_t pend_m, en_src;

  always_comb begin
    pend_m = sip_wr_i ? (bit_w(IRQ_SSI) & ideleg_q) : PEND_M;
    en_src = sie_wr_i ? ((mie_q & ~ideleg_q) | (wdata_i & ideleg_q)) : wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mip_q    <= '0;
      mie_q    <= '0;
      ideleg_q <= '0;
      edeleg_q <= '0;
    end else begin
      if (mip_wr_i || sip_wr_i) mip_q <= (mip_q & ~pend_m) | (wdata_i & pend_m);
      if (mie_wr_i || sie_wr_i) mie_q <= (mie_q & ~IRQ_ALL_MASK) | (en_src & IRQ_ALL_MASK);
      if (ideleg_wr_i) ideleg_q <= wdata_i & IRQ_DELEG_MASK;
      if (edeleg_wr_i) edeleg_q <= wdata_i & EXC_DELEG_MASK;
    end
  end

  assign mip_o    = mip_q;
  assign mie_o    = mie_q;
  assign ideleg_o = ideleg_q;
  assign edeleg_o = edeleg_q;
  assign sip_o    = mip_q & ideleg_q;
  assign sie_o    = mie_q & ideleg_q;

  a_r1_ideleg_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ideleg_q & ~IRQ_DELEG_MASK) == '0);
  a_r2_edeleg_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edeleg_q & ~EXC_DELEG_MASK) == '0);
  a_r7_sip_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sip_wr_i && !mip_wr_i && !ideleg_q[IRQ_SSI]) |=> $stable(mip_q));
endmodule

// File: rtl/csr_retire_cnt.sv
module csr_retire_cnt
  import csr_pkg::*;
#(
  parameter int HALF_W = XLEN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [HALF_W-1:0] wdata_i,
  input  logic              inc_i,
  output logic [HALF_W-1:0] lo_o,
  output logic [HALF_W-1:0] hi_o
);
  localparam int CNT_W = 2 * HALF_W;

  logic [CNT_W-1:0] cnt_q, merged, nxt;

  always_comb begin
    merged = cnt_q;
    if (wr_lo_i) merged[HALF_W-1:0] = wdata_i;
    if (wr_hi_i) merged[CNT_W-1:HALF_W] = wdata_i;
    // a write pre-compensates the increment of its own instruction
    nxt = merged + CNT_W'(inc_i) - CNT_W'(wr_lo_i || wr_hi_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else cnt_q <= nxt;
  end

  assign lo_o = cnt_q[HALF_W-1:0];
  assign hi_o = cnt_q[CNT_W-1:HALF_W];

  a_r10_plain_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_lo_i && !wr_hi_i && inc_i) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_lo_i && !wr_hi_i && !inc_i) |=> $stable(cnt_q));
endmodule

// File: rtl/csr_warl_file.sv
module csr_warl_file
  import csr_pkg::*;
#(
  parameter bit          HAS_EXT  = 1'b0,
  parameter logic [31:0] MISA_RST = 32'h4014_112d,
  parameter int          HART_ID  = 0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [11:0] csr_addr_i,
  input  logic [31:0] csr_wdata_i,
  input  logic        csr_we_i,
  input  logic        csr_re_i,
  input  logic        pc_odd_half_i,
  input  logic        retire_i,
  output logic [31:0] csr_rdata_o,
  output logic        csr_illegal_o,
  output logic        tlb_flush_o
);
  localparam bit    HAS_U   = MISA_RST[ISA_U];
  localparam bit    HAS_S   = MISA_RST[ISA_S];
  localparam word_t ISA_WM  = ISA_RW_MASK & MISA_RST;

  word_t mstatus, sstatus, mip, mie, ideleg, edeleg, sip, sie, ret_lo, ret_hi;
  word_t misa_q, isa_val, rdata, plain_rd;
  logic  hit, ro, wr_ok, st_flush, flush_q, isa_refuse;
  logic [NPLAIN-1:0] plain_hit;
  word_t plain_q [NPLAIN];

  assign ro    = &csr_addr_i[11:10];
  assign wr_ok = csr_we_i && hit && !ro;

  function automatic logic wr_at(input logic ok, input logic [11:0] a, input logic [11:0] t);
    return ok && (a == t);
  endfunction

  // plain data registers with fixed cleared bits
  for (genvar g = 0; g < NPLAIN; g++) begin : g_plain
    localparam logic [11:0] ADDR = plain_addr(g);
    localparam word_t       KEEP = plain_keep(g);
    logic [11:0] addr_c;
    assign addr_c = ADDR;
    assign plain_hit[g] = (csr_addr_i == addr_c);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) plain_q[g] <= '0;
      else if (wr_ok && plain_hit[g]) plain_q[g] <= csr_wdata_i & KEEP;
    end
    if (KEEP != '1) begin : g_chk
      a_r5_low_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (plain_q[g] & ~KEEP) == '0);
    end
  end

  always_comb begin
    plain_rd = '0;
    for (int i = 0; i < NPLAIN; i++) if (plain_hit[i]) plain_rd = plain_rd | plain_q[i];
  end

  csr_status #(.HAS_U(HAS_U), .HAS_S(HAS_S), .HAS_EXT(HAS_EXT)) i_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mwr_i       (wr_at(wr_ok, csr_addr_i, A_MSTATUS)),
    .swr_i       (wr_at(wr_ok, csr_addr_i, A_SSTATUS)),
    .wdata_i     (csr_wdata_i),
    .mstatus_o   (mstatus),
    .sstatus_o   (sstatus),
    .flush_req_o (st_flush)
  );

  csr_irq i_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mip_wr_i    (wr_at(wr_ok, csr_addr_i, A_MIP)),
    .sip_wr_i    (wr_at(wr_ok, csr_addr_i, A_SIP)),
    .mie_wr_i    (wr_at(wr_ok, csr_addr_i, A_MIE)),
    .sie_wr_i    (wr_at(wr_ok, csr_addr_i, A_SIE)),
    .ideleg_wr_i (wr_at(wr_ok, csr_addr_i, A_MIDELEG)),
    .edeleg_wr_i (wr_at(wr_ok, csr_addr_i, A_MEDELEG)),
    .wdata_i     (csr_wdata_i),
    .mip_o       (mip),
    .mie_o       (mie),
    .ideleg_o    (ideleg),
    .edeleg_o    (edeleg),
    .sip_o       (sip),
    .sie_o       (sie)
  );

  csr_retire_cnt #(.HALF_W(XLEN)) i_retire (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_lo_i (wr_at(wr_ok, csr_addr_i, A_RET_LO)),
    .wr_hi_i (wr_at(wr_ok, csr_addr_i, A_RET_HI)),
    .wdata_i (csr_wdata_i),
    .inc_i   (retire_i),
    .lo_o    (ret_lo),
    .hi_o    (ret_hi)
  );

  // misa: a write dropping compressed support would strand a 2-byte aligned PC
  always_comb begin
    isa_val = csr_wdata_i;
    if (!csr_wdata_i[ISA_F]) isa_val[ISA_D] = 1'b0;
    isa_refuse = !csr_wdata_i[ISA_C] && pc_odd_half_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) misa_q <= MISA_RST;
    else if (wr_at(wr_ok, csr_addr_i, A_MISA) && !isa_refuse)
      misa_q <= (misa_q & ~ISA_WM) | (isa_val & ISA_WM);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flush_q <= 1'b0;
    else flush_q <= st_flush || wr_at(wr_ok, csr_addr_i, A_SATP);
  end

  always_comb begin
    hit   = 1'b1;
    rdata = '0;
    unique case (csr_addr_i)
      A_MSTATUS: rdata = mstatus;
      A_SSTATUS: rdata = sstatus;
      A_MISA:    rdata = misa_q;
      A_MEDELEG: rdata = edeleg;
      A_MIDELEG: rdata = ideleg;
      A_MIE:     rdata = mie;
      A_MIP:     rdata = mip;
      A_SIE:     rdata = sie;
      A_SIP:     rdata = sip;
      A_RET_LO:  rdata = ret_lo;
      A_RET_HI:  rdata = ret_hi;
      A_ID_VEND, A_ID_ARCH, A_ID_IMPL: rdata = '0;
      A_ID_HART: rdata = word_t'(HART_ID);
      default: begin
        hit   = |plain_hit;
        rdata = plain_rd;
      end
    endcase
  end

  assign csr_rdata_o   = rdata;
  assign csr_illegal_o = (csr_we_i || csr_re_i) && (!hit || (csr_we_i && ro));
  assign tlb_flush_o   = flush_q;

  a_r6_misa_refuse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && csr_addr_i == A_MISA && !csr_wdata_i[ISA_C] && pc_odd_half_i) |=> $stable(misa_q));
  a_r9_flush_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlb_flush_o |-> $past(csr_we_i));
  a_r11_illegal_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_illegal_o && !csr_we_i) |-> csr_rdata_o == '0);
endmodule

// File: tb/test_csr_warl_file.sv
module test_csr_warl_file;
  import csr_pkg::*;
  localparam int CLK_PERIOD = 10;

  typedef enum logic [1:0] {K_RD, K_FL, K_IL} kind_e;
  typedef struct {
    kind_e       kind;
    logic [31:0] data;
    logic        ill;
    string       tag;
  } item_t;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0, re = 1'b0, pc_odd = 1'b0, retire = 1'b0, mon_en = 1'b0;
  logic [31:0] rdata;
  logic        illegal, flush;
  item_t       sb[$];
  int          n_vec = 0, n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  csr_warl_file #(.HART_ID(3)) i_csr_warl_file (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .csr_addr_i    (addr),
    .csr_wdata_i   (wdata),
    .csr_we_i      (we),
    .csr_re_i      (re),
    .pc_odd_half_i (pc_odd),
    .retire_i      (retire),
    .csr_rdata_o   (rdata),
    .csr_illegal_o (illegal),
    .tlb_flush_o   (flush)
  );

  task automatic push(input kind_e k, input logic [31:0] d, input logic il, input string t);
    item_t it;
    it.kind = k; it.data = d; it.ill = il; it.tag = t;
    sb.push_back(it);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic ret = 1'b0);
    @(posedge clk); #1;
    addr = a; wdata = d; we = 1'b1; re = 1'b0; retire = ret; mon_en = 1'b0;
  endtask

  task automatic wr_ill(input logic [11:0] a, input logic [31:0] d, input logic exp, input string t);
    @(posedge clk); #1;
    addr = a; wdata = d; we = 1'b1; re = 1'b0; retire = 1'b0; mon_en = 1'b1;
    push(K_IL, '0, exp, t);
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string t, input logic il = 1'b0);
    @(posedge clk); #1;
    addr = a; we = 1'b0; re = 1'b1; retire = 1'b0; mon_en = 1'b1;
    push(K_RD, exp, il, t);
  endtask

  task automatic fl(input logic exp, input string t);
    @(posedge clk); #1;
    we = 1'b0; re = 1'b0; retire = 1'b0; mon_en = 1'b1;
    push(K_FL, '0, exp, t);
  endtask

  task automatic idle(input logic ret = 1'b0);
    @(posedge clk); #1;
    we = 1'b0; re = 1'b0; retire = ret; mon_en = 1'b0;
  endtask

  // monitor: compare in the middle of each checked cycle
  always @(negedge clk) begin
    if (mon_en) begin
      item_t it;
      n_vec++;
      if (sb.size() == 0) begin
        n_bad++;
        $display("FAIL scoreboard empty: act rdata=%h exp item", rdata);
      end else begin
        it = sb.pop_front();
        case (it.kind)
          K_RD: if (rdata !== it.data || illegal !== it.ill) begin
            n_bad++;
            $display("FAIL %s: act data=%h ill=%b exp data=%h ill=%b", it.tag, rdata, illegal, it.data, it.ill);
          end
          K_FL: if (flush !== it.ill) begin
            n_bad++;
            $display("FAIL %s: act flush=%b exp flush=%b", it.tag, flush, it.ill);
          end
          default: if (illegal !== it.ill) begin
            n_bad++;
            $display("FAIL %s: act ill=%b exp ill=%b", it.tag, illegal, it.ill);
          end
        endcase
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_bad++;
    $display("FAIL watchdog: act running exp finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    rd(A_MSTATUS, 32'h0, "R12 status reset");
    rd(A_MISA, 32'h4014_112d, "R12 misa reset");
    rd(A_MEPC, 32'h0, "R12 mepc reset");

    wr(A_MIDELEG, 32'hffff_ffff);
    rd(A_MIDELEG, 32'h0000_1222, "R1 ideleg mask");
    wr(A_MIE, 32'hffff_ffff);
    rd(A_MIE, 32'h0000_12aa, "R1 mie mask");
    wr(A_MEDELEG, 32'hffff_ffff);
    rd(A_MEDELEG, 32'h0000_b109, "R2 edeleg mask");

    wr(A_MSTATUS, 32'h0000_1000);
    fl(1'b0, "R9 no flush when fields unchanged");
    rd(A_MSTATUS, 32'h0, "R3 mpp H becomes U");
    wr(A_MSTATUS, 32'hffff_ffff);
    fl(1'b1, "R9 flush on mpp/mprv change");
    rd(A_MSTATUS, 32'h807e_79aa, "R4 all writable plus SD");
    wr(A_MSTATUS, 32'h0000_2008);
    rd(A_MSTATUS, 32'h0000_2008, "R4 FS not dirty no SD");
    wr(A_SSTATUS, 32'hffff_ffff);
    fl(1'b1, "R9 flush on sum/mxr change");
    rd(A_SSTATUS, 32'h800c_6122, "R8 supervisor status view");
    rd(A_MSTATUS, 32'h800c_612a, "R8 machine bits kept");
    wr(A_SSTATUS, 32'h0);
    rd(A_MSTATUS, 32'h0000_0008, "R8 MIE untouched by view");

    wr(A_MEPC, 32'hffff_ffff);
    rd(A_MEPC, 32'hffff_fffe, "R5 mepc bit0");
    wr(A_MTVEC, 32'hffff_ffff);
    rd(A_MTVEC, 32'hffff_fffd, "R5 mtvec bit1");
    wr(A_STVEC, 32'hffff_ffff);
    rd(A_STVEC, 32'hffff_fffc, "R5 stvec low bits");
    wr(A_DPC, 32'h1234_5677);
    rd(A_DPC, 32'h1234_5676, "R5 dpc bit0");
    wr(A_SEPC, 32'h0000_0003);
    rd(A_SEPC, 32'h0000_0002, "R5 sepc bit0");

    wr(A_MISA, 32'h0);
    rd(A_MISA, 32'h4014_0100, "R6 clear writable letters");
    wr(A_MISA, 32'hffff_ffff);
    rd(A_MISA, 32'h4014_112d, "R6 restore supported only");
    wr(A_MISA, 32'hffff_ffdf);
    rd(A_MISA, 32'h4014_1105, "R6 F clear drops D");
    pc_odd = 1'b1;
    wr(A_MISA, 32'h0);
    rd(A_MISA, 32'h4014_1105, "R6 C clear refused on odd half");
    wr(A_MISA, 32'hffff_ffff);
    rd(A_MISA, 32'h4014_112d, "R6 C kept write accepted");
    pc_odd = 1'b0;

    wr(A_MIP, 32'hffff_ffff);
    rd(A_MIP, 32'h0000_0022, "R7 mip writable bits");
    wr(A_MIP, 32'h0);
    wr(A_SIP, 32'hffff_ffff);
    rd(A_SIP, 32'h0000_0002, "R7 sip delegated write");
    rd(A_MIP, 32'h0000_0002, "R7 mip after sip");
    wr(A_MIDELEG, 32'h0000_0020);
    wr(A_SIP, 32'h0);
    rd(A_MIP, 32'h0000_0002, "R7 sip write undelegated ignored");
    rd(A_SIP, 32'h0, "R7 sip read masked");
    wr(A_SIE, 32'h0);
    rd(A_MIE, 32'h0000_128a, "R7 sie changes delegated only");
    rd(A_SIE, 32'h0, "R7 sie read masked");

    wr(A_SATP, 32'h8000_0001);
    fl(1'b1, "R9 flush on satp write");
    rd(A_SATP, 32'h8000_0001, "R9 satp stored");
    wr(A_MSCRATCH, 32'ha5a5_a5a5);
    fl(1'b0, "R9 no flush other write");
    rd(A_MSCRATCH, 32'ha5a5_a5a5, "R11 scratch legal");

    wr(A_RET_LO, 32'h0000_0010);
    rd(A_RET_LO, 32'h0000_000f, "R10 low write minus one");
    rd(A_RET_HI, 32'h0, "R10 high untouched");
    wr(A_RET_HI, 32'h0000_0005);
    rd(A_RET_HI, 32'h0000_0005, "R10 high write");
    rd(A_RET_LO, 32'h0000_000e, "R10 high write decrements");
    wr(A_RET_LO, 32'h0);
    rd(A_RET_HI, 32'h0000_0004, "R10 borrow into high");
    rd(A_RET_LO, 32'hffff_ffff, "R10 low wraps");
    wr(A_RET_LO, 32'h0000_0100, 1'b1);
    rd(A_RET_LO, 32'h0000_0100, "R10 write with retire");
    idle(1'b1);
    rd(A_RET_LO, 32'h0000_0101, "R10 retire increments");

    rd(12'h7c0, 32'h0, "R11 unimplemented read", 1'b1);
    rd(A_ID_VEND, 32'h0, "R11 vendor id");
    rd(A_ID_HART, 32'h3, "R11 hart id");
    wr_ill(A_ID_HART, 32'h5, 1'b1, "R11 write read-only");
    rd(A_ID_HART, 32'h3, "R11 read-only unchanged");
    wr_ill(12'h7c0, 32'h1, 1'b1, "R11 write unimplemented");
    wr_ill(A_MTVAL, 32'h1, 1'b0, "R11 legal write");
    idle();
    idle();

    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard leftover: act %0d exp 0", sb.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule